// File: doc/BRIEF.md
# Self-Calibrating Switching Threshold Controller

This block chooses the level at which a tooth/notch sensor's output should switch. It takes a stream of signed, digitised field samples and finds the local minima (notches) and maxima (teeth) in that stream. From those extremes it derives a weighted threshold. A 7-bit programmable fraction places the threshold between the minimum and the maximum. The output stage compares the field against this threshold and reports each output transition back as a one-cycle switching-event pulse.

After reset the block runs in a start-up mode. In that mode the threshold is either a stored static value or, if nothing is stored, the present field value. Once a first notch/tooth pair has been found, the block moves to a coarse tracking mode. In this mode every new pair pulls the threshold toward its target by a bounded step. After a fixed number of switching events the block moves to a fine tracking mode. Fine tracking gathers the absolute extremes over a window of switching events and lets the threshold creep by one count only after several windows agree on the direction.

Two plausibility watchdogs send the block back to the start-up mode and raise a one-cycle short-reset request. The first fires when the output has not switched for a long time, measured in clock-enable ticks. The second fires when several extremes arrive with no switching event between them.

Top module: `thrcal_top`

## Requirements
- R1: In start-up mode the threshold equals `static_thr` while `static_ok` is 1. While `static_ok` is 0, the threshold takes the value of each valid sample.
- R2: An extreme is reported only after the signal has moved back from its running peak or trough by more than `RETREAT` counts; a smaller retreat produces no event. Once a minimum and a maximum have both been reported, the block leaves start-up mode for coarse mode.
- R3: In coarse mode each completed minimum/maximum pair moves the threshold toward its target by at most `PRE_STEP` counts.
- R4: The target is `(min*(128-K) + max*K) >>> 7`, saturated to the threshold width. K is the 7-bit `kfac`, read as a binary fraction whose MSB is worth one half (0x60 = 0.75, 0x00 = 0). When `kfac_ok` is 0, K = 0x40.
- R5: Coarse mode changes to fine mode on its 64th switching event. The 63rd event leaves the mode unchanged.
- R6: In fine mode a correction is evaluated only when a window of 32 switching events closes, using the extremes seen in that window. The threshold changes only when the current correction is the fourth or later in an unbroken run pointing the same way.
- R7: In fine mode a window changes the threshold by at most 1 count. Each further same-direction window past the fourth changes it immediately.
- R8: A correction that points the other way starts the run again at one, so three more windows pass with no change.
- R9: In fine mode a correction whose magnitude is not above `DEADBAND` leaves the threshold unchanged, even inside a qualifying run.
- R10: `mode_out` encodes 0 = start-up, 1 = coarse, 2 = fine and never shows 3. Reset gives mode 0, threshold 0 and `short_rst` low.
- R11: If four extremes are reported with no switching event among them, `short_rst` pulses and the mode returns to 0.
- R12: If `WDOG_TICKS` ticks of `tick_en` pass with no switching event, `short_rst` pulses and the mode returns to 0. A switching event restarts this count.
- R13: `short_rst` is high for exactly one cycle. In the following cycle the mode is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow time-base enable for the no-switch watchdog |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SW | Signed field sample |
| static_thr | input | SW | Stored static threshold (signed) |
| static_ok | input | 1 | Static threshold has been programmed |
| kfac | input | 7 | Weighting fraction K |
| kfac_ok | input | 1 | K has been programmed |
| sw_evt | input | 1 | One-cycle pulse per output transition |
| thr_out | output | SW | Active switching threshold (signed) |
| mode_out | output | 2 | Current operating mode |
| short_rst | output | 1 | One-cycle self-reset request |

## Verification
The assertions assume the extreme tracker never reports a maximum and a minimum in the same cycle. They also assume that switching events reach the block as single-cycle pulses, so each window count and stall count moves by at most one per cycle. The stimulus holds every sample for one cycle and then idles for three. It sends switching events only as isolated pulses, apart from samples. It drives the tick enable only in the watchdog scenario. As a result, no extreme ever coincides with a switching event or with the closing cycle of a window.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic [1:0] {
        MODE_INIT   = 2'd0,
        MODE_PRECAL = 2'd1,
        MODE_CAL    = 2'd2
    } mode_e;
endpackage

// File: rtl/thr_peak_trk.sv
module thr_peak_trk #(
    parameter int SW      = 12,
    parameter int RETREAT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 vld,
    input  logic signed [SW-1:0] smp,
    output logic                 max_evt,
    output logic                 min_evt,
    output logic signed [SW-1:0] ext_val
);
    localparam logic signed [SW:0] RET_L = (SW+1)'(RETREAT);

    typedef struct packed {
        logic          seeded;
        logic          rising;
        logic [SW-1:0] run;
        logic          max_evt;
        logic          min_evt;
        logic [SW-1:0] ev;
    } trk_t;

    trk_t q, d;
    logic signed [SW:0] gap_dn, gap_up;

    always_comb begin
        d         = q;
        d.max_evt = 1'b0;
        d.min_evt = 1'b0;
        gap_dn    = $signed({q.run[SW-1], q.run}) - $signed({smp[SW-1], smp});
        gap_up    = $signed({smp[SW-1], smp}) - $signed({q.run[SW-1], q.run});
        if (clr) begin
            d = '0;
        end else if (vld) begin
            if (!q.seeded) begin
                d.seeded = 1'b1;
                d.rising = 1'b1;
                d.run    = smp;
            end else if (q.rising) begin
                if ($signed(smp) > $signed(q.run)) begin
                    d.run = smp;
                end else if (gap_dn > RET_L) begin
                    d.max_evt = 1'b1;
                    d.ev      = q.run;
                    d.rising  = 1'b0;
                    d.run     = smp;
                end
            end else begin
                if ($signed(smp) < $signed(q.run)) begin
                    d.run = smp;
                end else if (gap_up > RET_L) begin
                    d.min_evt = 1'b1;
                    d.ev      = q.run;
                    d.rising  = 1'b1;
                    d.run     = smp;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign max_evt = q.max_evt;
    assign min_evt = q.min_evt;
    assign ext_val = $signed(q.ev);

    // R2: after a maximum the tracker is falling, so no second maximum follows at once
    a_r2_no_double_max: assert property (@(posedge clk) disable iff (!rst_n)
        q.max_evt |=> !q.max_evt);
    a_r2_no_double_min: assert property (@(posedge clk) disable iff (!rst_n)
        q.min_evt |=> !q.min_evt);
endmodule

// File: rtl/thr_wavg.sv
module thr_wavg #(
    parameter int SW = 12,
    parameter int KW = 7
) (
    input  logic signed [SW-1:0] lo,
    input  logic signed [SW-1:0] hi,
    input  logic        [KW-1:0] k,
    output logic signed [SW-1:0] val
);
    localparam int PW = SW + KW + 2;
    localparam logic [KW:0] KSCALE = (KW+1)'(2**KW);
    localparam logic signed [PW-1:0] MAXV = PW'(2**(SW-1) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic        [KW:0]   kc;
    logic signed [PW-1:0] plo, phi, sum, shf;

    always_comb begin
        kc  = KSCALE - {1'b0, k};
        plo = $signed({{(PW-SW){lo[SW-1]}}, lo}) * $signed({{(PW-KW-1){1'b0}}, kc});
        phi = $signed({{(PW-SW){hi[SW-1]}}, hi}) * $signed({{(PW-KW){1'b0}}, k});
        sum = plo + phi;
        shf = sum >>> KW;
        if (shf > MAXV)      val = MAXV[SW-1:0];
        else if (shf < MINV) val = MINV[SW-1:0];
        else                 val = shf[SW-1:0];
    end
endmodule

// File: rtl/thr_dirfilt.sv
module thr_dirfilt #(
    parameter int DW       = 14,
    parameter int FILT_N   = 4,
    parameter int DEADBAND = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 vld,
    input  logic signed [DW-1:0] diff,
    output logic signed [1:0]    step
);
    localparam int CW = $clog2(FILT_N + 1);
    localparam logic signed [DW-1:0] DB = DW'(DEADBAND);

    typedef struct packed {
        logic          dir;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;
    logic up, nz;
    logic signed [DW-1:0] mag;

    always_comb begin
        d    = q;
        step = 2'sb00;
        up   = !diff[DW-1];
        nz   = |diff;
        mag  = up ? diff : -diff;
        if (clr) begin
            d = '0;
        end else if (vld) begin
            if (!nz) begin
                d.cnt = '0;
            end else begin
                if (q.cnt != '0 && q.dir == up) begin
                    if (q.cnt < CW'(FILT_N)) d.cnt = q.cnt + CW'(1);
                end else begin
                    d.cnt = CW'(1);
                    d.dir = up;
                end
                if (d.cnt >= CW'(FILT_N) && mag > DB)
                    step = up ? 2'sb01 : 2'sb11;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a step needs an unbroken run of earlier corrections in the same direction
    a_r6_run_before_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !clr && step != 2'sb00) |-> (q.cnt >= CW'(FILT_N - 1) && q.dir == (step == 2'sb01)));
endmodule

// File: rtl/thrcal_top.sv
module thrcal_top
    import thr_pkg::*;
#(
    parameter int SW           = 12,
    parameter int RETREAT      = 8,
    parameter int PRE_STEP     = 16,
    parameter int PRE_EVENTS   = 64,
    parameter int CAL_WIN      = 32,
    parameter int STALL_EVENTS = 4,
    parameter int FILT_N       = 4,
    parameter int DEADBAND     = 1,
    parameter int WDOG_TICKS   = 12000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 smp_vld,
    input  logic signed [SW-1:0] smp,
    input  logic signed [SW-1:0] static_thr,
    input  logic                 static_ok,
    input  logic [6:0]           kfac,
    input  logic                 kfac_ok,
    input  logic                 sw_evt,
    output logic signed [SW-1:0] thr_out,
    output logic [1:0]           mode_out,
    output logic                 short_rst
);
    localparam int KW  = 7;
    localparam int DW  = SW + 2;
    localparam int PCW = $clog2(PRE_EVENTS);
    localparam int WCW = $clog2(CAL_WIN);
    localparam int SCW = $clog2(STALL_EVENTS + 1);
    localparam int TCW = $clog2(WDOG_TICKS);
    localparam logic [KW-1:0] K_HALF = KW'(2**(KW-1));
    localparam logic signed [DW-1:0] PSTEP = DW'(PRE_STEP);

    typedef struct packed {
        mode_e          mode;
        logic [SW-1:0]  thr;
        logic [SW-1:0]  lo;
        logic [SW-1:0]  hi;
        logic           lo_ok;
        logic           hi_ok;
        logic           pair;
        logic [SW-1:0]  wlo;
        logic [SW-1:0]  whi;
        logic           wlo_ok;
        logic           whi_ok;
        logic           wend;
        logic [PCW-1:0] pcnt;
        logic [WCW-1:0] wcnt;
        logic [SCW-1:0] scnt;
        logic [TCW-1:0] tcnt;
        logic           srst;
    } ctl_t;

    ctl_t q, d;

    logic                 max_evt, min_evt, any_evt;
    logic signed [SW-1:0] ext_val, tgt, wa_lo, wa_hi;
    logic        [KW-1:0] k_eff;
    logic signed [DW-1:0] diff, delta;
    logic signed [1:0]    fstep;
    logic                 f_vld, stall_hit, time_hit;

    thr_peak_trk #(.SW(SW), .RETREAT(RETREAT)) u_trk (
        .clk(clk), .rst_n(rst_n), .clr(q.srst), .vld(smp_vld), .smp(smp),
        .max_evt(max_evt), .min_evt(min_evt), .ext_val(ext_val)
    );

    assign k_eff = kfac_ok ? kfac : K_HALF;
    assign wa_lo = (q.mode == MODE_CAL) ? $signed(q.wlo) : $signed(q.lo);
    assign wa_hi = (q.mode == MODE_CAL) ? $signed(q.whi) : $signed(q.hi);

    thr_wavg #(.SW(SW), .KW(KW)) u_wavg (
        .lo(wa_lo), .hi(wa_hi), .k(k_eff), .val(tgt)
    );

    assign diff  = $signed({{2{tgt[SW-1]}}, tgt}) - $signed({{2{q.thr[SW-1]}}, q.thr});
    assign f_vld = (q.mode == MODE_CAL) && q.wend && q.wlo_ok && q.whi_ok;

    thr_dirfilt #(.DW(DW), .FILT_N(FILT_N), .DEADBAND(DEADBAND)) u_flt (
        .clk(clk), .rst_n(rst_n), .clr(q.mode != MODE_CAL), .vld(f_vld),
        .diff(diff), .step(fstep)
    );

    always_comb begin
        d       = q;
        d.pair  = 1'b0;
        d.wend  = 1'b0;
        d.srst  = 1'b0;
        any_evt = max_evt | min_evt;

        if (diff > PSTEP)       delta = PSTEP;
        else if (diff < -PSTEP) delta = -PSTEP;
        else                    delta = diff;

        // plausibility counters
        if (sw_evt)       d.scnt = '0;
        else if (any_evt) d.scnt = q.scnt + SCW'(1);
        if (sw_evt)       d.tcnt = '0;
        else if (tick_en) d.tcnt = q.tcnt + TCW'(1);
        stall_hit = any_evt && !sw_evt && (q.scnt == SCW'(STALL_EVENTS - 1));
        time_hit  = tick_en && !sw_evt && (q.tcnt == TCW'(WDOG_TICKS - 1));

        case (q.mode)
            MODE_INIT, MODE_PRECAL: begin
                if (q.mode == MODE_INIT) begin
                    if (static_ok)    d.thr = static_thr;
                    else if (smp_vld) d.thr = smp;
                end
                if (max_evt) begin
                    d.hi = ext_val;
                    if (q.lo_ok) begin d.pair = 1'b1; d.lo_ok = 1'b0; d.hi_ok = 1'b0; end
                    else d.hi_ok = 1'b1;
                end
                if (min_evt) begin
                    d.lo = ext_val;
                    if (q.hi_ok) begin d.pair = 1'b1; d.lo_ok = 1'b0; d.hi_ok = 1'b0; end
                    else d.lo_ok = 1'b1;
                end
                if (q.pair) begin
                    d.thr = q.thr + delta[SW-1:0];
                    if (q.mode == MODE_INIT) begin
                        d.mode = MODE_PRECAL;
                        d.pcnt = '0;
                    end
                end
                if (q.mode == MODE_PRECAL && sw_evt) begin
                    if (q.pcnt == PCW'(PRE_EVENTS - 1)) begin
                        d.mode   = MODE_CAL;
                        d.wcnt   = '0;
                        d.wlo_ok = 1'b0;
                        d.whi_ok = 1'b0;
                    end else begin
                        d.pcnt = q.pcnt + PCW'(1);
                    end
                end
            end
            MODE_CAL: begin
                if (max_evt && (!q.whi_ok || $signed(ext_val) > $signed(q.whi))) begin
                    d.whi    = ext_val;
                    d.whi_ok = 1'b1;
                end
                if (min_evt && (!q.wlo_ok || $signed(ext_val) < $signed(q.wlo))) begin
                    d.wlo    = ext_val;
                    d.wlo_ok = 1'b1;
                end
                if (sw_evt) begin
                    if (q.wcnt == WCW'(CAL_WIN - 1)) begin
                        d.wcnt = '0;
                        d.wend = 1'b1;
                    end else begin
                        d.wcnt = q.wcnt + WCW'(1);
                    end
                end
                if (q.wend) begin
                    d.thr    = q.thr + {{(SW-2){fstep[1]}}, fstep};
                    d.wlo_ok = 1'b0;
                    d.whi_ok = 1'b0;
                end
            end
            default: d.mode = MODE_INIT;
        endcase

        if (stall_hit || time_hit) begin
            d      = '0;
            d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign thr_out   = $signed(q.thr);
    assign mode_out  = q.mode;
    assign short_rst = q.srst;

    a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q.mode != 2'd3);

    a_r3_pre_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_PRECAL && $past(q.mode) == MODE_PRECAL) |->
        ((int'($signed(q.thr)) - int'($signed($past(q.thr))) <= PRE_STEP) &&
         (int'($signed($past(q.thr))) - int'($signed(q.thr)) <= PRE_STEP)));

    a_r7_cal_one_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_CAL && $past(q.mode) == MODE_CAL) |->
        ((int'($signed(q.thr)) - int'($signed($past(q.thr))) <= 1) &&
         (int'($signed($past(q.thr))) - int'($signed(q.thr)) <= 1)));

    a_r13_srst_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> (!q.srst && q.mode == MODE_INIT));
endmodule

// File: tb/sim_thrcal_top.sv
module sim_thrcal_top;
    localparam int SW = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick_en = 1'b0;
    logic                 smp_vld = 1'b0;
    logic signed [SW-1:0] smp = '0;
    logic signed [SW-1:0] static_thr = 12'sd50;
    logic                 static_ok = 1'b0;
    logic [6:0]           kfac = 7'h00;
    logic                 kfac_ok = 1'b0;
    logic                 sw_evt = 1'b0;
    logic signed [SW-1:0] thr_out;
    logic [1:0]           mode_out;
    logic                 short_rst;

    int n_chk = 0;
    int n_bad = 0;
    int rst_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thrcal_top #(.SW(SW), .WDOG_TICKS(100)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .smp_vld(smp_vld), .smp(smp),
        .static_thr(static_thr), .static_ok(static_ok), .kfac(kfac), .kfac_ok(kfac_ok),
        .sw_evt(sw_evt), .thr_out(thr_out), .mode_out(mode_out), .short_rst(short_rst)
    );

    always @(posedge clk) if (short_rst) rst_cnt <= rst_cnt + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_sample(input int v);
        @(negedge clk);
        smp = SW'(v); smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sw(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sw_evt = 1'b1;
            @(negedge clk); sw_evt = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
    endtask

    // R10, R1: reset state, then start-up threshold sources
    task automatic t_startup();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 reset mode", int'(mode_out), 0);
        chk("R10 reset thr", int'(thr_out), 0);
        chk("R10 reset short_rst", int'(short_rst), 0);
        send_sample(37);
        chk("R1 unprogrammed follows sample", int'(thr_out), 37);
        @(negedge clk); static_ok = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 static threshold", int'(thr_out), 50);
        chk("R1 still start-up", int'(mode_out), 0);
    endtask

    // R2, R3, R4, R5: pair detection, coarse steps, weighting, mode change
    task automatic t_coarse();
        send_sample(200);
        send_sample(-200);
        chk("R2 one extreme stays start-up", int'(mode_out), 0);
        pulse_sw(1);
        send_sample(200);
        chk("R2 pair enters coarse", int'(mode_out), 1);
        chk("R4 default half target clamped R3", int'(thr_out), 34);
        pulse_sw(1);
        kfac = 7'h60; kfac_ok = 1'b1;
        for (int p = 0; p < 4; p++) begin
            send_sample(-200); pulse_sw(1);
            send_sample(200);
            chk("R3 step limited toward 0.75 target", int'(thr_out), 50 + 16 * p);
            pulse_sw(1);
        end
        send_sample(-200); pulse_sw(1);
        send_sample(200);
        chk("R4 0.75 target reached", int'(thr_out), 100);
        pulse_sw(1);
        send_sample(-200); pulse_sw(1);
        send_sample(200);
        chk("R3 no change at target", int'(thr_out), 100);
        pulse_sw(1);
        // 13 switching events so far in coarse mode
        pulse_sw(50);
        chk("R5 63 events stay coarse", int'(mode_out), 1);
        pulse_sw(1);
        chk("R5 64th event enters fine", int'(mode_out), 2);
    endtask

    task automatic cal_window(input int a, input int b);
        send_sample(a);
        send_sample(b);
        pulse_sw(32);
    endtask

    // R6, R7, R8, R9: fine-mode filter
    task automatic t_fine();
        cal_window(-100, 300);
        chk("R6 first window no change", int'(thr_out), 100);
        cal_window(-100, 300);
        cal_window(-100, 300);
        chk("R6 third window no change", int'(thr_out), 100);
        send_sample(-100); send_sample(300);
        pulse_sw(31);
        chk("R6 no update before window closes", int'(thr_out), 100);
        pulse_sw(1);
        chk("R7 fourth window one count", int'(thr_out), 101);
        cal_window(-100, 300);
        chk("R7 fifth window immediate", int'(thr_out), 102);
        kfac = 7'h00;
        cal_window(-100, 300);
        cal_window(-100, 300);
        cal_window(-100, 300);
        chk("R8 reversed run of three holds", int'(thr_out), 102);
        cal_window(-100, 300);
        chk("R8 fourth reversed window steps", int'(thr_out), 101);
        kfac = 7'h40;
        cal_window(-100, 300);
        chk("R9 one count inside dead-band", int'(thr_out), 101);
        kfac = 7'h00;
        cal_window(-100, 300);
        chk("R9 run kept after dead-band", int'(thr_out), 100);
    endtask

    // R11, R2, R13: stall watchdog
    task automatic t_stall();
        int base;
        base = rst_cnt;
        send_sample(295);
        send_sample(-100);
        send_sample(300);
        send_sample(-100);
        chk("R2 small retreat gives no event R11", rst_cnt - base, 0);
        chk("R11 three extremes keep mode", int'(mode_out), 2);
        send_sample(300);
        chk("R11 fourth extreme requests reset", rst_cnt - base, 1);
        chk("R13 back to start-up", int'(mode_out), 0);
        chk("R13 single pulse", int'(short_rst), 0);
        chk("R1 static restored", int'(thr_out), 50);
    endtask

    // R12: time watchdog
    task automatic t_timer();
        int base;
        base = rst_cnt;
        pulse_sw(1);
        run_ticks(95);
        pulse_sw(1);
        run_ticks(95);
        chk("R12 restarted count no reset", rst_cnt - base, 0);
        run_ticks(10);
        chk("R12 expiry requests reset", rst_cnt - base, 1);
        chk("R12 mode start-up", int'(mode_out), 0);
    endtask

    initial begin
        t_startup();
        t_coarse();
        t_fine();
        t_stall();
        t_timer();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule